// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a word-addressed scratchpad split into 32 banks of 32-bit words, with consecutive word addresses placed in consecutive banks. It accepts one request from a group of 32 lanes. Each lane carries a word address, an enable, a read/write flag and write data. The block cannot serve two different rows of one bank in the same cycle. It therefore splits the request into wavefronts. In each wavefront every bank serves at most one distinct address, and every pending lane that wants that address is served in the same pass.

At the end the block reports how many wavefronts the request took. This count equals the worst number of distinct addresses any single bank received, so the client can use it to measure the conflict cost of a memory layout. For example, it can compare a plain row-major layout with an XOR-swizzled one. Per-lane read data is held on the outputs until the next request is accepted.

Top module: `spad_conflict_serializer`

## Requirements
- R1: A lane's bank is bits [4:0] of its word address, which is the byte address divided by 4 taken modulo 32. The row within the bank is bits [8:5]. A request whose active lanes all fall in different banks finishes in one wavefront.
- R2: `waveCount` equals the largest number of distinct active addresses that map to any one bank. For example, 16 lanes on 16 rows of bank 0 plus 16 lanes on 16 rows of bank 1 give 16, and two rows in each of 16 banks give 2.
- R3: Active lanes that share one address are served in the same wavefront. Every reading lane among them returns the same stored word.
- R4: Inactive lanes add nothing to any bank's count, write nothing, and return zero read data.
- R5: `busy` is high from the cycle after the accepting edge of `start`. `done` is a one-cycle pulse in the cycle where `busy` falls. `done` appears exactly max(`waveCount`,1) clock edges after the accepting edge. A request with no active lanes reports 0.
- R6: `start` raised while `busy` is high is ignored. Its writes never reach memory and it does not restart the current request.
- R7: Among active writes to one address in a request, the highest-numbered lane's data is stored. A read of an address that the same request writes returns the word held before the request.
- R8: After `done`, each active reading lane presents its word on its slice of `laneRdata` (lane i at bits [32i+31:32i]). Writing and inactive lanes present zero. The values hold until the next accepted `start`.
- R9: During and after reset, `busy`, `done`, `waveCount` and `laneRdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the lane request (only when idle) |
| laneValid | input | 32 | Per-lane enable |
| laneWrite | input | 32 | Per-lane write flag (1 = write, 0 = read) |
| laneAddr | input | 288 | Per-lane 9-bit word address, lane i at [9i+8:9i] |
| laneWdata | input | 1024 | Per-lane write word, lane i at [32i+31:32i] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| waveCount | output | 6 | Wavefronts used by the last request |
| laneRdata | output | 1024 | Per-lane read word, lane i at [32i+31:32i] |

## Verification
The cycle-level rules are checked by the assertions on every cycle. These cover the handshake (`busy` after `start`, `done` only as `busy` falls and never twice in a row), the rule that a wavefront serves only pending lanes and always serves at least one while work remains, the rule that a `start` during `busy` leaves the pending set alone, and the bound on the count.

Only the bench scenarios can show that the count is minimal for a given conflict pattern. They also show that the correct word reaches each lane, including under broadcast, that the highest lane wins a write collision, that reads ordered against writes see the old value, and that an ignored request leaves memory unchanged. The bench does this against a shadow copy of memory.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;  // capture a new lane request
    logic step;  // perform one wavefront
  } spadStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spadState_t;
endpackage

// File: rtl/spad_bank_array.sv
module spad_bank_array #(
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  localparam int NB    = 1 << BANK_W,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic                          clk,
  input  logic [NB-1:0]                 bankWe,
  input  logic [NB-1:0][ROW_W-1:0]      bankRow,
  input  logic [NB-1:0][DATA_W-1:0]     bankWdata,
  output logic [NB-1:0][DATA_W-1:0]     bankRdata
);
  // One single-ported bank per generate step; read is combinational at the
  // served row, so a same-cycle write is seen only from the next cycle on.
  for (genvar g = 0; g < NB; g++) begin : gBank
    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
      if (bankWe[g]) mem[bankRow[g]] <= bankWdata[g];
    end

    assign bankRdata[g] = mem[bankRow[g]];
  end
endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        lastWave,
  output spadStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  spadState_t stateQ, stateD;

  always_comb begin
    strobe      = '0;
    stateD      = stateQ;
    strobe.load = (stateQ == ST_IDLE) && start;
    strobe.step = (stateQ == ST_RUN);
    if (stateQ == ST_IDLE && start)   stateD = ST_RUN;
    if (stateQ == ST_RUN && lastWave) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= (stateQ == ST_RUN) && lastWave;
    end
  end

  assign busy = (stateQ == ST_RUN);
endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  localparam int ADDR_W = BANK_W + ROW_W,
  localparam int NB     = 1 << BANK_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  spadStrobe_t                    strobe,
  input  logic [LANES-1:0]               laneValid,
  input  logic [LANES-1:0]               laneWrite,
  input  logic [LANES-1:0][ADDR_W-1:0]   laneAddr,
  input  logic [LANES-1:0][DATA_W-1:0]   laneWdata,
  input  logic [NB-1:0][DATA_W-1:0]      bankRdata,
  output logic [NB-1:0]                  bankWe,
  output logic [NB-1:0][ROW_W-1:0]       bankRow,
  output logic [NB-1:0][DATA_W-1:0]      bankWdata,
  output logic                           lastWave,
  output logic [LANES-1:0]               pendingMask,
  output logic [LANES-1:0]               serveMask,
  output logic [CNT_W-1:0]               waveCount,
  output logic [LANES-1:0][DATA_W-1:0]   laneRdata
);
  logic [LANES-1:0]             pendingQ;
  logic [LANES-1:0]             wrQ;
  logic [LANES-1:0][ADDR_W-1:0] addrQ;
  logic [LANES-1:0][DATA_W-1:0] wdataQ;
  logic [LANES-1:0][DATA_W-1:0] rdataQ;
  logic [CNT_W-1:0]             countQ;

  // Per bank: the address of the lowest-numbered pending lane in that bank
  logic [NB-1:0][ADDR_W-1:0]    leadAddr;
  logic [LANES-1:0]             serve;

  always_comb begin
    leadAddr = '0;
    for (int b = 0; b < NB; b++) begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pendingQ[l] && addrQ[l][BANK_W-1:0] == BANK_W'(b)) leadAddr[b] = addrQ[l];
      end
    end
  end

  // A lane is served when its address matches its bank's leader (broadcast)
  always_comb begin
    serve = '0;
    for (int l = 0; l < LANES; l++) begin
      serve[l] = pendingQ[l] && (leadAddr[addrQ[l][BANK_W-1:0]] == addrQ[l]);
    end
  end

  // Bank ports: row from the leader, write data from the highest served writer
  always_comb begin
    bankWe    = '0;
    bankWdata = '0;
    for (int b = 0; b < NB; b++) begin
      bankRow[b] = leadAddr[b][ADDR_W-1:BANK_W];
      for (int l = 0; l < LANES; l++) begin
        if (serve[l] && wrQ[l] && addrQ[l][BANK_W-1:0] == BANK_W'(b)) begin
          bankWe[b]    = 1'b1;
          bankWdata[b] = wdataQ[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendingQ <= '0;
      wrQ      <= '0;
      addrQ    <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      countQ   <= '0;
    end else if (strobe.load) begin
      pendingQ <= laneValid;
      wrQ      <= laneWrite;
      addrQ    <= laneAddr;
      wdataQ   <= laneWdata;
      rdataQ   <= '0;
      countQ   <= '0;
    end else if (strobe.step) begin
      pendingQ <= pendingQ & ~serve;
      if (|pendingQ) countQ <= countQ + 1'b1;
      for (int l = 0; l < LANES; l++) begin
        if (serve[l] && !wrQ[l]) rdataQ[l] <= bankRdata[addrQ[l][BANK_W-1:0]];
      end
    end
  end

  assign lastWave    = ((pendingQ & ~serve) == '0);
  assign pendingMask = pendingQ;
  assign serveMask   = serve;
  assign waveCount   = countQ;
  assign laneRdata   = rdataQ;
endmodule

// File: rtl/spad_conflict_serializer.sv
module spad_conflict_serializer
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 32,
  localparam int ADDR_W = BANK_W + ROW_W,
  localparam int NB     = 1 << BANK_W,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LANES-1:0]          laneValid,
  input  logic [LANES-1:0]          laneWrite,
  input  logic [LANES*ADDR_W-1:0]   laneAddr,
  input  logic [LANES*DATA_W-1:0]   laneWdata,
  output logic                      busy,
  output logic                      done,
  output logic [CNT_W-1:0]          waveCount,
  output logic [LANES*DATA_W-1:0]   laneRdata
);
  spadStrobe_t               strobe;
  logic                      lastWave;
  logic [LANES-1:0]          pendingMask;
  logic [LANES-1:0]          serveMask;
  logic [NB-1:0]             bankWe;
  logic [NB-1:0][ROW_W-1:0]  bankRow;
  logic [NB-1:0][DATA_W-1:0] bankWdata;
  logic [NB-1:0][DATA_W-1:0] bankRdata;

  spad_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .lastWave (lastWave),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  spad_datapath #(
    .LANES (LANES), .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .laneValid   (laneValid),
    .laneWrite   (laneWrite),
    .laneAddr    (laneAddr),
    .laneWdata   (laneWdata),
    .bankRdata   (bankRdata),
    .bankWe      (bankWe),
    .bankRow     (bankRow),
    .bankWdata   (bankWdata),
    .lastWave    (lastWave),
    .pendingMask (pendingMask),
    .serveMask   (serveMask),
    .waveCount   (waveCount),
    .laneRdata   (laneRdata)
  );

  spad_bank_array #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) uBanks (
    .clk       (clk),
    .bankWe    (bankWe),
    .bankRow   (bankRow),
    .bankWdata (bankWdata),
    .bankRdata (bankRdata)
  );
endmodule

// File: rtl/spad_checker.sv
module spad_checker #(
  parameter int LANES = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] waveCount,
  input logic [LANES-1:0] pendingMask,
  input logic [LANES-1:0] serveMask
);
  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && ((pendingMask & ~serveMask) != '0))
      |=> (pendingMask == $past(pendingMask & ~serveMask)));

  assert_serve_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((serveMask & ~pendingMask) == '0));

  assert_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pendingMask != '0) |-> (serveMask != '0));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (waveCount <= CNT_W'(LANES)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (waveCount == $past(waveCount) || waveCount == $past(waveCount) + 1'b1));
endmodule

bind spad_conflict_serializer spad_checker #(.LANES(LANES), .CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .waveCount   (waveCount),
  .pendingMask (pendingMask),
  .serveMask   (serveMask)
);

// File: tb/tb_spad_conflict_serializer.sv
`timescale 1ns/1ps
module tb_spad_conflict_serializer;
  localparam int L = 32;
  localparam int AW = 9;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [L-1:0]    laneValid, laneWrite;
  logic [L*AW-1:0] laneAddr;
  logic [L*DW-1:0] laneWdata;
  logic            busy, done;
  logic [5:0]      waveCount;
  logic [L*DW-1:0] laneRdata;

  always #2 clk = ~clk;  // 250 MHz

  spad_conflict_serializer dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .laneValid(laneValid), .laneWrite(laneWrite),
    .laneAddr(laneAddr), .laneWdata(laneWdata),
    .busy(busy), .done(done), .waveCount(waveCount), .laneRdata(laneRdata)
  );

  // Lane request arrays driven by the scenarios
  logic          bVld [L];
  logic          bWr  [L];
  logic [AW-1:0] bAddr[L];
  logic [DW-1:0] bWd  [L];

  always_comb begin
    for (int l = 0; l < L; l++) begin
      laneValid[l]          = bVld[l];
      laneWrite[l]          = bWr[l];
      laneAddr[l*AW +: AW]  = bAddr[l];
      laneWdata[l*DW +: DW] = bWd[l];
    end
  end

  logic [DW-1:0] shadow [512];
  int checks = 0;
  int errors = 0;

  // Expectations captured when a request is prepared
  int            expWaves;
  logic [DW-1:0] expRd [L];
  logic          sVld [L];
  logic          sWr  [L];
  logic [AW-1:0] sAddr[L];
  logic [DW-1:0] sWd  [L];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'(a) * 32'h9E37_79B1 + DW'(salt);
  endfunction

  task automatic clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b0; bWr[l] = 1'b0; bAddr[l] = '0; bWd[l] = '0;
    end
  endtask

  // Expected count: max distinct active addresses in any bank (R2, R4)
  task automatic prepare();
    int perBank [32];
    for (int b = 0; b < 32; b++) perBank[b] = 0;
    expWaves = 0;
    for (int l = 0; l < L; l++) begin
      bit fresh;
      sVld[l] = bVld[l]; sWr[l] = bWr[l]; sAddr[l] = bAddr[l]; sWd[l] = bWd[l];
      expRd[l] = (bVld[l] && !bWr[l]) ? shadow[bAddr[l]] : '0;
      fresh = bVld[l];
      for (int k = 0; k < l; k++) if (bVld[k] && bAddr[k] == bAddr[l]) fresh = 1'b0;
      if (fresh) begin
        perBank[bAddr[l][4:0]]++;
        if (perBank[bAddr[l][4:0]] > expWaves) expWaves = perBank[bAddr[l][4:0]];
      end
    end
  endtask

  task automatic issue();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R5", "busy after start", busy, 1);
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic verify(input string req, input int lat, input int expLat);
    chk(done == 1'b1, "R5", "done pulse", done, 1);
    chk(busy == 1'b0, "R5", "busy low at done", busy, 0);
    if (expLat > 0) chk(lat == expLat, "R5", "latency", lat, expLat);
    chk(waveCount == 6'(expWaves), req, "wavefront count", waveCount, expWaves);
    for (int l = 0; l < L; l++)
      chk(laneRdata[l*DW +: DW] == expRd[l], "R8", $sformatf("lane %0d data", l),
          laneRdata[l*DW +: DW], expRd[l]);
    // apply writes in ascending lane order: highest lane wins (R7)
    for (int l = 0; l < L; l++) if (sVld[l] && sWr[l]) shadow[sAddr[l]] = sWd[l];
    @(negedge clk);
    chk(done == 1'b0, "R5", "done is one cycle", done, 0);
  endtask

  task automatic runReq(input string req);
    int lat;
    prepare();
    issue();
    waitDone(lat);
    verify(req, lat, (expWaves == 0) ? 1 : expWaves);
  endtask

  task automatic testReset();
    chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
    chk(done == 1'b0, "R9", "done in reset", done, 0);
    chk(waveCount == 6'd0, "R9", "count in reset", waveCount, 0);
    chk(laneRdata == '0, "R9", "read data in reset", 0, 0);
  endtask

  // R1: each row written by 32 lanes hitting 32 different banks
  task automatic testFill();
    for (int r = 0; r < 16; r++) begin
      clearLanes();
      for (int l = 0; l < L; l++) begin
        bVld[l] = 1'b1; bWr[l] = 1'b1; bAddr[l] = AW'(r * 32 + l); bWd[l] = pat(r * 32 + l, 7);
      end
      runReq("R1");
    end
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'(((l * 5) % 16) * 32 + l);
    end
    runReq("R1");
  endtask

  // R2: 16 rows of bank 0 and 16 rows of bank 1 read together
  task automatic testColumnConflict();
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'((l % 16) * 32 + (l / 16));
    end
    runReq("R2");
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'((l / 16) * 32 + (l % 16));
    end
    runReq("R2");
  endtask

  // R3: all lanes read one word
  task automatic testBroadcast();
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'(37);
    end
    runReq("R3");
    for (int l = 1; l < L; l++)
      chk(laneRdata[l*DW +: DW] == laneRdata[0 +: DW], "R3", "broadcast equal",
          laneRdata[l*DW +: DW], laneRdata[0 +: DW]);
  endtask

  // R4: inactive lanes carry conflicting addresses and writes
  task automatic testInactive();
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bWr[l] = (l % 2 == 1); bAddr[l] = AW'((l % 16) * 32); bWd[l] = 32'hDEAD_0000 + DW'(l);
    end
    bVld[0] = 1'b1; bWr[0] = 1'b0; bAddr[0] = AW'(0);
    bVld[5] = 1'b1; bWr[5] = 1'b0; bAddr[5] = AW'(5);
    runReq("R4");
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'((l % 16) * 32 + 0);
    end
    runReq("R4");  // memory unchanged: bank 0 rows still hold fill values
  endtask

  task automatic testEmpty();
    clearLanes();
    runReq("R5");
  endtask

  // R7: write collision plus a read of the same address
  task automatic testWriteOrder();
    clearLanes();
    for (int l = 0; l < 4; l++) begin
      bVld[l] = 1'b1; bWr[l] = 1'b1; bAddr[l] = AW'(100); bWd[l] = 32'h7700_0000 + DW'(l);
    end
    bVld[4] = 1'b1; bAddr[4] = AW'(100);
    runReq("R7");
    chk(laneRdata[4*DW +: DW] == pat(100, 7), "R7", "read sees old value",
        laneRdata[4*DW +: DW], pat(100, 7));
    clearLanes();
    bVld[9] = 1'b1; bAddr[9] = AW'(100);
    runReq("R7");
    chk(laneRdata[9*DW +: DW] == 32'h7700_0003, "R7", "highest lane stored",
        laneRdata[9*DW +: DW], 32'h7700_0003);
    clearLanes();
    bVld[0] = 1'b1; bWr[0] = 1'b1; bAddr[0] = AW'(64); bWd[0] = 32'h1234_5678;
    bVld[1] = 1'b1; bAddr[1] = AW'(32);
    runReq("R2");
  endtask

  // R6: a second start during a 16-wavefront request
  task automatic testIgnoredStart();
    int lat;
    clearLanes();
    for (int l = 0; l < L; l++) begin
      bVld[l] = 1'b1; bAddr[l] = AW'((l % 16) * 32 + (l / 16));
    end
    prepare();
    issue();
    clearLanes();
    bVld[0] = 1'b1; bWr[0] = 1'b1; bAddr[0] = AW'(0); bWd[0] = 32'hBAD0_BAD0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    verify("R6", lat + 1, 16);
    clearLanes();
    bVld[3] = 1'b1; bAddr[3] = AW'(0);
    runReq("R6");
    chk(laneRdata[3*DW +: DW] == pat(0, 7), "R6", "ignored write absent",
        laneRdata[3*DW +: DW], pat(0, 7));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearLanes();
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFill();
    testColumnConflict();
    testBroadcast();
    testInactive();
    testEmpty();
    testWriteOrder();
    testIgnoredStart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule